// File: doc/BRIEF.md
# External Interrupt Sense and Pending Controller

This block watches eight active-low external interrupt pins and turns them into interrupt requests for a CPU. Software picks, for each channel, whether the pin requests while it is held low or whether a falling edge latches a request. Software also picks whether new requests are accepted on that channel. The choices sit in two 8-bit write/read registers, one for sense mode and one for enable, with bit n belonging to channel n.

An edge-mode request stays latched in a pending flag until the CPU acknowledges it by channel index. The flag also survives a later clear of the channel's enable bit, and in that state it still reaches the CPU while the global interrupt mask is open. Only a specific combination clears a stale flag quietly: mask set, sense bit 0 and enable bit 0, all in the same cycle. The block produces a request vector, a combined request gated by the CPU's mask input, and the index of the lowest-numbered active channel.

Top module: `irq_sense_ctrl`

## Requirements
- R1: After reset, both configuration registers read 0 (every channel level-sensed and disabled), `chan_req` is 0, `cpu_req` is 0 and `req_idx` is 0.
- R2: A write strobe loads `cfg_wdata` into the sense register (`sense_we`) or the enable register (`enable_we`) on the clock edge. The new value reads back on `sense_rd` or `enable_rd`, and bit n belongs to channel n.
- R3: With sense bit n = 0 (level mode) and no pending flag, `chan_req[n]` is 1 exactly while enable bit n is 1 and the synchronized pin n is low. It drops when the pin returns high.
- R4: With sense bit n = 1 (falling-edge mode) and enable bit n = 1, a falling edge on pin n sets the channel's pending flag. `chan_req[n]` then stays 1 after the pin returns high.
- R5: A falling edge on a channel whose enable bit is 0 sets no pending flag, and `chan_req[n]` stays 0.
- R6: Clearing enable bit n while the pending flag is set leaves the flag set, and `chan_req[n]` stays 1.
- R7: A pending flag on a disabled channel drives `cpu_req` to 1 whenever `cpu_mask` is 0.
- R8: The pending flag of channel n clears when, in the same cycle, `cpu_mask` is 1, sense bit n is 0 and enable bit n is 0. With any one of the three missing, the flag stays set.
- R9: A one-cycle `ack_valid` with `ack_idx` = n clears channel n's pending flag when sense bit n is 1. The acknowledge leaves other channels alone, and a level-mode request is unaffected by it.
- R10: `cpu_req` is the OR of all `chan_req` bits when `cpu_mask` is 0, and is 0 whenever `cpu_mask` is 1. `chan_req` itself is not gated by the mask.
- R11: `req_idx` is the lowest n with `chan_req[n]` = 1, and 0 when none is set.
- R12: Each pin passes through two flip-flops before sensing, so a level request appears on the second clock edge after the pin falls and not on the first. An edge is a 1-to-0 step of the synchronized value, so a pin already low when edge mode is selected latches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 8 | External interrupt pins, active low, asynchronous |
| sense_we | input | 1 | Write strobe for the sense register |
| enable_we | input | 1 | Write strobe for the enable register |
| cfg_wdata | input | 8 | Write data for both registers |
| sense_rd | output | 8 | Sense register, 1 = falling edge, 0 = low level |
| enable_rd | output | 8 | Enable register, 1 = new requests accepted |
| cpu_mask | input | 1 | CPU global interrupt mask, 1 = masked |
| ack_valid | input | 1 | One-cycle acknowledge from the CPU |
| ack_idx | input | 3 | Channel being acknowledged |
| chan_req | output | 8 | Per-channel request, not mask-gated |
| cpu_req | output | 1 | Combined request to the CPU |
| req_idx | output | 3 | Lowest-numbered active channel |

## Verification
The channel assertions rely on the sense and enable bits changing only on clock edges through the write strobes, and on `ack_valid` being a single-cycle pulse sampled with a stable index. The bench meets this by driving every input on the falling clock edge. Register writes and acknowledges each last exactly one cycle. Pins are held for at least three cycles between changes, so every step passes fully through the synchronizer before the next one arrives.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  parameter int unsigned IRQ_CHANNELS = 8;
  parameter int unsigned IRQ_SYNC_STAGES = 2;

  localparam logic MODE_LEVEL = 1'b0;
  localparam logic MODE_FALL = 1'b1;

  // falling step of a synchronized active-low pin
  function automatic logic is_fall(input logic prev_v, input logic cur_v);
    return prev_v & ~cur_v;
  endfunction

  // quiet clear of a stale pending flag
  function automatic logic quiet_clear(input logic mask_v, input logic sense_v,
                                       input logic en_v);
    return mask_v & (sense_v == MODE_LEVEL) & ~en_v;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned N = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_s
);
  logic [N-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign pin_s = stg[STAGES-1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sense_we,
  input  logic         enable_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] sense_q,
  output logic [N-1:0] enable_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q  <= '0;
      enable_q <= '0;
    end else begin
      if (sense_we)  sense_q  <= wdata;
      if (enable_we) enable_q <= wdata;
    end
  end

  a_r2_sense_load: assert property (@(posedge clk) disable iff (!rst_n)
    sense_we |=> sense_q == $past(wdata));
  a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
    enable_we |=> enable_q == $past(wdata));
endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import irq_sense_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic sense_i,
  input  logic en_i,
  input  logic mask_i,
  input  logic ack_hit_i,
  output logic req_o
);
  logic prev_q;
  logic pend_q;
  logic fall_evt;
  logic set_evt;
  logic ack_clr;
  logic quiet_clr;
  logic level_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  assign fall_evt  = is_fall(prev_q, pin_s);
  assign set_evt   = (sense_i == MODE_FALL) & en_i & fall_evt;
  assign ack_clr   = ack_hit_i & (sense_i == MODE_FALL);
  assign quiet_clr = quiet_clear(mask_i, sense_i, en_i);

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (set_evt)                pend_q <= 1'b1;
    else if (ack_clr || quiet_clr)   pend_q <= 1'b0;
  end

  assign level_req = (sense_i == MODE_LEVEL) & en_i & ~pin_s;
  assign req_o     = pend_q | level_req;

  a_r4_fall_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && en_i && fall_evt) |=> pend_q);
  a_r5_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_i && sense_i));
  a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_hit_i && !(mask_i && !sense_i && !en_i)) |=> pend_q);
  a_r8_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i && !sense_i && !en_i) |=> !pend_q);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit_i && sense_i && !fall_evt) |=> !pend_q);
  a_r3_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_i && !pend_q) |-> (req_o == (en_i && !pin_s)));
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  function automatic logic [W-1:0] first_set(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = W'(i);
    end
    return r;
  endfunction

  assign idx_o = first_set(vec_i);
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
#(
  parameter int unsigned N = IRQ_CHANNELS,
  parameter int unsigned SYNC = IRQ_SYNC_STAGES,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_pin_n,
  input  logic          sense_we,
  input  logic          enable_we,
  input  logic [N-1:0]  cfg_wdata,
  output logic [N-1:0]  sense_rd,
  output logic [N-1:0]  enable_rd,
  input  logic          cpu_mask,
  input  logic          ack_valid,
  input  logic [IW-1:0] ack_idx,
  output logic [N-1:0]  chan_req,
  output logic          cpu_req,
  output logic [IW-1:0] req_idx
);
  logic [N-1:0] pin_s;
  logic [N-1:0] sense_q;
  logic [N-1:0] enable_q;
  logic [N-1:0] ack_hit;
  logic         any_req;

  irq_pin_sync #(.N(N), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(irq_pin_n), .pin_s(pin_s)
  );

  irq_cfg_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .sense_we(sense_we), .enable_we(enable_we),
    .wdata(cfg_wdata), .sense_q(sense_q), .enable_q(enable_q)
  );

  generate
    for (genvar g = 0; g < N; g++) begin : g_chan
      assign ack_hit[g] = ack_valid && (ack_idx == IW'(g));
      irq_chan u_chan (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s[g]), .sense_i(sense_q[g]),
        .en_i(enable_q[g]), .mask_i(cpu_mask), .ack_hit_i(ack_hit[g]),
        .req_o(chan_req[g])
      );
    end
  endgenerate

  irq_lowest #(.N(N)) u_pick (
    .vec_i(chan_req), .idx_o(req_idx), .any_o(any_req)
  );

  assign cpu_req   = any_req & ~cpu_mask;
  assign sense_rd  = sense_q;
  assign enable_rd = enable_q;

  a_r10_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mask |-> !cpu_req);
  a_r10_any_reaches: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_mask && chan_req != '0) |-> cpu_req);
  a_r11_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req != '0) |-> (chan_req[req_idx] &&
      ((chan_req & ((N'(1) << req_idx) - N'(1))) == '0)));
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req == '0) |-> (req_idx == '0));
endmodule

// File: tb/sim_irq_sense_ctrl.sv
module sim_irq_sense_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_pin_n = 8'hFF;
  logic       sense_we = 1'b0;
  logic       enable_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] sense_rd;
  logic [7:0] enable_rd;
  logic       cpu_mask = 1'b0;
  logic       ack_valid = 1'b0;
  logic [2:0] ack_idx = 3'd0;
  logic [7:0] chan_req;
  logic       cpu_req;
  logic [2:0] req_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_sense_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .sense_we(sense_we),
    .enable_we(enable_we), .cfg_wdata(cfg_wdata), .sense_rd(sense_rd),
    .enable_rd(enable_rd), .cpu_mask(cpu_mask), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .chan_req(chan_req), .cpu_req(cpu_req), .req_idx(req_idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sense(input logic [7:0] v);
    sense_we = 1'b1; cfg_wdata = v; cyc(1); sense_we = 1'b0;
  endtask

  task automatic wr_enable(input logic [7:0] v);
    enable_we = 1'b1; cfg_wdata = v; cyc(1); enable_we = 1'b0;
  endtask

  task automatic pulse_pin(input int n);
    irq_pin_n[n] = 1'b0; cyc(3); irq_pin_n[n] = 1'b1; cyc(3);
  endtask

  task automatic ack(input logic [2:0] n);
    ack_valid = 1'b1; ack_idx = n; cyc(1); ack_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 sense", sense_rd, 0);
    chk("R1 enable", enable_rd, 0);
    chk("R1 chan_req", chan_req, 0);
    chk("R1 cpu_req", cpu_req, 0);
    chk("R1 req_idx", req_idx, 0);
  endtask

  task automatic t_regs;
    wr_sense(8'hA5);
    wr_enable(8'h3C);
    chk("R2 sense readback", sense_rd, 8'hA5);
    chk("R2 enable readback", enable_rd, 8'h3C);
    wr_sense(8'h00);
    wr_enable(8'h00);
    chk("R2 cleared", {sense_rd, enable_rd}, 0);
  endtask

  task automatic t_level;
    wr_enable(8'h08);
    irq_pin_n[3] = 1'b0;
    cyc(1);
    chk("R12 not after one edge", chan_req, 0);
    cyc(1);
    chk("R12 after two edges", chan_req, 8'h08);
    chk("R3 level cpu_req", cpu_req, 1);
    chk("R11 idx 3", req_idx, 3);
    irq_pin_n[3] = 1'b1; cyc(3);
    chk("R3 level drops", chan_req, 0);
    irq_pin_n[4] = 1'b0; cyc(3);
    chk("R3 disabled level", chan_req, 0);
    irq_pin_n[4] = 1'b1; cyc(3);
    wr_enable(8'h00);
  endtask

  task automatic t_edge_ack;
    wr_sense(8'h02); wr_enable(8'h02);
    pulse_pin(1);
    chk("R4 pending held", chan_req, 8'h02);
    ack(3'd1);
    chk("R9 ack clears", chan_req, 0);
    wr_sense(8'h00); wr_enable(8'h00);
  endtask

  task automatic t_disabled_edge;
    wr_sense(8'h04);
    pulse_pin(2);
    chk("R5 edge ignored", chan_req, 0);
    chk("R5 no cpu_req", cpu_req, 0);
    wr_sense(8'h00);
  endtask

  task automatic t_hold_clear;
    wr_sense(8'h01); wr_enable(8'h01);
    pulse_pin(0);
    wr_enable(8'h00);
    chk("R6 held after disable", chan_req, 8'h01);
    chk("R7 reaches cpu", cpu_req, 1);
    cpu_mask = 1'b1; cyc(1);
    chk("R10 masked cpu_req", cpu_req, 0);
    chk("R10 chan_req ungated", chan_req, 8'h01);
    cyc(2);
    chk("R8 held while sense=1", chan_req, 8'h01);
    cpu_mask = 1'b0;
    wr_sense(8'h00); cyc(2);
    chk("R8 held while mask=0", chan_req, 8'h01);
    cpu_mask = 1'b1; cyc(2);
    chk("R8 quiet clear", chan_req, 0);
    cpu_mask = 1'b0;
  endtask

  task automatic t_ack_select;
    wr_sense(8'h60); wr_enable(8'h70);
    irq_pin_n[4] = 1'b0;
    pulse_pin(5); pulse_pin(6);
    chk("R11 idx lowest", req_idx, 4);
    ack(3'd4);
    chk("R9 ack level no effect", chan_req, 8'h70);
    ack(3'd5);
    chk("R9 ack one channel", chan_req, 8'h50);
    irq_pin_n[4] = 1'b1; cyc(3);
    chk("R11 idx 6", req_idx, 6);
    ack(3'd6);
    chk("R9 all acked", chan_req, 0);
    wr_sense(8'h00); wr_enable(8'h00);
  endtask

  task automatic t_priority;
    wr_enable(8'hFF);
    irq_pin_n[7] = 1'b0; irq_pin_n[2] = 1'b0; cyc(3);
    chk("R11 two active", req_idx, 2);
    irq_pin_n[2] = 1'b1; cyc(3);
    chk("R11 only top", req_idx, 7);
    chk("R10 any", cpu_req, 1);
    irq_pin_n[7] = 1'b1; cyc(3);
    chk("R11 none", req_idx, 0);
    wr_enable(8'h00);
  endtask

  task automatic t_low_at_switch;
    wr_enable(8'h80);
    irq_pin_n[7] = 1'b0; cyc(3);
    chk("R3 level ch7", chan_req, 8'h80);
    wr_sense(8'h80); cyc(2);
    chk("R12 no edge when already low", chan_req, 0);
    irq_pin_n[7] = 1'b1; cyc(3);
    irq_pin_n[7] = 1'b0; cyc(3);
    chk("R12 real edge latches", chan_req, 8'h80);
    cpu_mask = 1'b1;
    wr_enable(8'h00); wr_sense(8'h00); cyc(1);
    chk("R8 cleared ch7", chan_req, 0);
    irq_pin_n[7] = 1'b1; cpu_mask = 1'b0; cyc(3);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_level();
    t_edge_ack();
    t_disabled_edge();
    t_hold_clear();
    t_ack_select();
    t_priority();
    t_low_at_switch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule